// File: doc/BRIEF.md
# Fixed-Frame Command Adapter

This block links a byte-wide host stream to an internal register command bus. Every host transaction is a frame of exactly `NUM_BYTES` (default 8) bytes. The leading byte is the register address. The bytes that follow are payload. A register that needs fewer bytes has its useful bytes at the front of the frame and zero padding behind them.

Once a frame is complete, the adapter issues a one-cycle command to the register engine. It then waits for the engine's completion strobe. After that it returns exactly `NUM_BYTES` bytes to the host. If the address is marked as a query register in the `QUERY_MAP` parameter, the returned bytes are the engine's read data. Otherwise they are zero filler.

The adapter takes no new frame until the host has drained the whole response. Host software therefore runs a strict send-frame, read-frame loop.

Top module: `frame_cmd_adapter`

## Requirements
- R1: After reset, `in_ready_o` is 1, while `out_valid_o` and `cmd_valid_o` are 0.
- R2: `in_ready_o` is high only while a frame is being collected. It never coincides with `out_valid_o` or `cmd_valid_o`.
- R3: In the cycle after the last frame byte is accepted, `cmd_valid_o` is high for exactly one cycle. At that point `cmd_addr_o` equals frame byte 0, and frame byte k (k = 1..NUM_BYTES-1) appears on `cmd_payload_o[8k-1:8k-8]`.
- R4: From the accepted last frame byte until the response starts, `in_ready_o` stays 0 and `out_valid_o` stays 0, however long the engine takes.
- R5: The response starts in the cycle after `done_i` is sampled high while the command is outstanding.
- R6: With the default map, addresses 0x10 to 0x1F are query registers. For these, response byte j equals `done_data_i[8j+7:8j]` as sampled with `done_i`, and byte 0 is sent first.
- R7: For any address whose `QUERY_MAP` bit is 0, every response byte is 0x00.
- R8: Exactly `NUM_BYTES` bytes are handed over on the output stream. The cycle after the last one, `out_valid_o` is 0 and `in_ready_o` is 1.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value.
- R10: A `done_i` pulse while no command is outstanding produces no response, and the adapter stays ready for a frame.
- R11: Bytes offered on the input while `in_ready_o` is 0 are not captured. The next frame is assembled only from bytes accepted after it reopens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Inbound frame byte |
| in_valid_i | input | 1 | Inbound byte valid |
| in_ready_o | output | 1 | Adapter accepts a frame byte |
| out_data_o | output | 8 | Response byte |
| out_valid_o | output | 1 | Response byte valid |
| out_ready_i | input | 1 | Host takes the response byte |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_addr_o | output | 8 | Register address (frame byte 0) |
| cmd_payload_o | output | 8*(NUM_BYTES-1) | Frame bytes 1 and up, byte 1 in the low bits |
| done_i | input | 1 | Register task complete |
| done_data_i | input | 8*NUM_BYTES | Read data, response byte 0 in the low bits |

## Verification
The assertions assume the engine raises `done_i` only after it has seen `cmd_valid_o`. They also assume the host changes `out_ready_i` and the input stream only between clock edges.

The response-count property counts handshakes from each command strobe onward. It therefore relies on a command always preceding a response.

The stimulus drives every input at the falling edge. It raises `done_i` only after observing the command strobe, except for one deliberately stray pulse while idle. It offers input bytes during the busy phase only to show that they are refused.

// File: rtl/fca_pkg.sv
package fca_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {ST_COLLECT, ST_ISSUE, ST_WAIT, ST_SEND} fca_state_e;
endpackage

// File: rtl/fca_rx_collect.sv
module fca_rx_collect
  import fca_pkg::*;
#(
  parameter int NUM_BYTES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  byte_t                  data_i,
  input  logic                   valid_i,
  output byte_t [NUM_BYTES-1:0]  frame_o,
  output logic                   full_o
);
  localparam int CNT_W = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES-1);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = en_i & valid_i;
  assign full_o = accept && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_o <= '0;
    end else if (accept) begin
      frame_o[cnt_q] <= data_i;
      cnt_q          <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fca_tx_serial.sv
module fca_tx_serial
  import fca_pkg::*;
#(
  parameter int NUM_BYTES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  byte_t [NUM_BYTES-1:0]  load_data_i,
  input  logic                   ready_i,
  output byte_t                  data_o,
  output logic                   valid_o,
  output logic                   drained_o
);
  localparam int CNT_W = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES-1);

  byte_t [NUM_BYTES-1:0] buf_q;
  logic [CNT_W-1:0]      idx_q;
  logic                  busy_q;
  logic                  fire;

  assign valid_o   = busy_q;
  assign data_o    = buf_q[idx_q];
  assign fire      = busy_q & ready_i;
  assign drained_o = fire && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      buf_q  <= load_data_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (fire) begin
      if (idx_q == LAST) begin
        idx_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fca_query_decode.sv
module fca_query_decode #(
  parameter int                      ADDR_W    = 8,
  parameter logic [2**ADDR_W-1:0]    QUERY_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_query_o
);
  assign is_query_o = QUERY_MAP[addr_i];
endmodule

// File: rtl/frame_cmd_adapter.sv
module frame_cmd_adapter
  import fca_pkg::*;
#(
  parameter int                  NUM_BYTES = 8,
  parameter logic [(1<<BYTE_W)-1:0] QUERY_MAP =
    {{((1<<BYTE_W)-32){1'b0}}, 16'hFFFF, 16'h0000},
  localparam int PAY_W  = BYTE_W*(NUM_BYTES-1),
  localparam int RESP_W = BYTE_W*NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_addr_o,
  output logic [PAY_W-1:0]  cmd_payload_o,
  input  logic              done_i,
  input  logic [RESP_W-1:0] done_data_i
);
  fca_state_e            state_q, state_d;
  byte_t [NUM_BYTES-1:0] frame;
  byte_t [NUM_BYTES-1:0] resp;
  logic                  frame_full, is_query, tx_load, tx_drained;

  assign in_ready_o  = (state_q == ST_COLLECT);
  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign tx_load     = (state_q == ST_WAIT) && done_i;
  assign cmd_addr_o  = frame[0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (frame_full) state_d = ST_ISSUE;
      ST_ISSUE:   state_d = ST_WAIT;
      ST_WAIT:    if (done_i) state_d = ST_SEND;
      ST_SEND:    if (tx_drained) state_d = ST_COLLECT;
      default:    state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_COLLECT;
    else         state_q <= state_d;
  end

  for (genvar k = 1; k < NUM_BYTES; k++) begin : g_pay
    assign cmd_payload_o[BYTE_W*(k-1) +: BYTE_W] = frame[k];
  end

  for (genvar j = 0; j < NUM_BYTES; j++) begin : g_resp
    assign resp[j] = is_query ? done_data_i[BYTE_W*j +: BYTE_W] : '0;
  end

  fca_rx_collect #(.NUM_BYTES(NUM_BYTES)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_ready_o),
    .data_i  (in_data_i),
    .valid_i (in_valid_i),
    .frame_o (frame),
    .full_o  (frame_full)
  );

  fca_query_decode #(.ADDR_W(BYTE_W), .QUERY_MAP(QUERY_MAP)) i_dec (
    .addr_i     (frame[0]),
    .is_query_o (is_query)
  );

  fca_tx_serial #(.NUM_BYTES(NUM_BYTES)) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tx_load),
    .load_data_i (resp),
    .ready_i     (out_ready_i),
    .data_o      (out_data_o),
    .valid_o     (out_valid_o),
    .drained_o   (tx_drained)
  );
endmodule

// File: rtl/fca_checker.sv
module fca_checker #(
  parameter int          NUM_BYTES = 8,
  parameter logic [255:0] QUERY_MAP = '0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       cmd_valid_o,
  input logic [7:0] cmd_addr_o
);
  localparam int CW = $clog2(NUM_BYTES+1);
  logic [CW-1:0] tx_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       tx_cnt <= CW'(NUM_BYTES);
    else if (cmd_valid_o)              tx_cnt <= '0;
    else if (out_valid_o && out_ready_i) tx_cnt <= tx_cnt + 1'b1;
  end

  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (!out_valid_o && !cmd_valid_o));
  p_cmd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  p_no_early_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> (!out_valid_o && !in_ready_o));
  p_cfg_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !QUERY_MAP[cmd_addr_o]) |-> (out_data_o == 8'h00));
  p_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (tx_cnt < CW'(NUM_BYTES)));
  p_reopen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> (tx_cnt == CW'(NUM_BYTES)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

bind frame_cmd_adapter fca_checker #(.NUM_BYTES(NUM_BYTES), .QUERY_MAP(QUERY_MAP)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_addr_o  (cmd_addr_o)
);

// File: tb/test_frame_cmd_adapter.sv
module test_frame_cmd_adapter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  out_data_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        cmd_valid_o;
  logic [7:0]  cmd_addr_o;
  logic [55:0] cmd_payload_o;
  logic        done_i = 1'b0;
  logic [63:0] done_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit timeout = 0;

  always #5 clk_i = ~clk_i;

  frame_cmd_adapter i_frame_cmd_adapter (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_query(logic [7:0] a);
    return (a >= 8'h10) && (a <= 8'h1F);
  endfunction

  // drive 8 bytes back to back, then check the command strobe (R3)
  task automatic send_frame(logic [63:0] f);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check("R2 ready while collecting", in_ready_o, 1'b1);
      in_valid_i = 1'b1;
      in_data_i  = f[8*i +: 8];
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R3 cmd_valid", cmd_valid_o, 1'b1);
    check("R3 cmd_addr", cmd_addr_o, f[7:0]);
    check("R3 cmd_payload", cmd_payload_o, f[63:8]);
    check("R4 ready low after frame", in_ready_o, 1'b0);
  endtask

  task automatic idle_wait(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check("R3 single pulse", cmd_valid_o, 1'b0);
      check("R4 no early response", out_valid_o, 1'b0);
      check("R4 ready held low", in_ready_o, 1'b0);
    end
  endtask

  task automatic finish_cmd(logic [63:0] d);
    done_i = 1'b1;
    done_data_i = d;
    @(negedge clk_i);
    done_i = 1'b0;
    done_data_i = ~d;
    check("R5 response starts", out_valid_o, 1'b1);
  endtask

  task automatic drain(logic [7:0] addr, logic [63:0] d, int stall_at);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = is_query(addr) ? d[8*i +: 8] : 8'h00;
      if (i == stall_at) begin
        out_ready_i = 1'b0;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk_i);
          check("R9 valid held", out_valid_o, 1'b1);
          check("R9 data held", out_data_o, e);
        end
      end
      check(is_query(addr) ? "R6 query byte" : "R7 config byte", out_data_o, e);
      check("R8 valid during drain", out_valid_o, 1'b1);
      out_ready_i = 1'b1;
      @(negedge clk_i);
    end
    out_ready_i = 1'b0;
    check("R8 valid drops after 8", out_valid_o, 1'b0);
    check("R8 ready reopens", in_ready_o, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 in_ready", in_ready_o, 1'b1);
    check("R1 out_valid", out_valid_o, 1'b0);
    check("R1 cmd_valid", cmd_valid_o, 1'b0);
  endtask

  task automatic t_config();
    logic [63:0] f = 64'h0000_0000_DDCC_BB03;
    send_frame(f);
    idle_wait(5);
    finish_cmd(64'h1122_3344_5566_7788);
    drain(f[7:0], 64'h1122_3344_5566_7788, -1);
  endtask

  task automatic t_query();
    logic [63:0] f = 64'h0000_0000_0000_0015;
    send_frame(f);
    idle_wait(1);
    finish_cmd(64'h8877_6655_4433_2211);
    drain(f[7:0], 64'h8877_6655_4433_2211, -1);
  endtask

  task automatic t_backpressure();
    logic [63:0] f = 64'h0807_0605_0403_021F;
    send_frame(f);
    idle_wait(2);
    finish_cmd(64'hF0E1_D2C3_B4A5_9687);
    drain(f[7:0], 64'hF0E1_D2C3_B4A5_9687, 2);
  endtask

  task automatic t_stray_done();
    @(negedge clk_i);
    done_i = 1'b1;
    done_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);
    done_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R10 no response", out_valid_o, 1'b0);
      check("R10 stays ready", in_ready_o, 1'b1);
      @(negedge clk_i);
    end
  endtask

  task automatic t_ignored_input();
    logic [63:0] f1 = 64'h0000_0000_0000_AA20;
    logic [63:0] f2 = 64'h7766_5544_3322_1112;
    send_frame(f1);
    in_valid_i = 1'b1;
    in_data_i  = 8'hEE;
    idle_wait(3);
    in_valid_i = 1'b0;
    finish_cmd(64'h0);
    drain(f1[7:0], 64'h0, -1);
    send_frame(f2);
    check("R11 addr after refusal", cmd_addr_o, f2[7:0]);
    check("R11 payload after refusal", cmd_payload_o, f2[63:8]);
    idle_wait(1);
    finish_cmd(64'hCAFE_F00D_1234_5678);
    drain(f2[7:0], 64'hCAFE_F00D_1234_5678, 7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_config();
        t_query();
        t_backpressure();
        t_stray_done();
        t_ignored_input();
      end
      begin
        repeat (100000) @(posedge clk_i);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule